// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a bus-programmed watchdog. A 16-bit up-counter advances on ticks taken from one of three tick strobes: the peripheral clock, the real-time clock or an external clock. Each strobe is a one-cycle enable in the single system clock domain. The chosen strobe first passes through a power-of-four prescaler. When the enabled counter reaches the programmed compare value, the block raises a chip reset request for a fixed number of system clocks. Software prevents this by writing the counter back to zero (a kick) before expiry.

Registers sit on a simple write/read port with byte or halfword writes and combinational read data. The control flow is a four-state machine:
- ST_IDLE: disabled.
- ST_COUNT: counting.
- ST_FIRE: reset request high.
- ST_HOLD: counter frozen after expiry.

The transitions are:
- ST_IDLE -> ST_COUNT when enabled.
- ST_COUNT -> ST_FIRE on a compare match with no counter write in the same cycle.
- ST_FIRE -> ST_HOLD after the last pulse cycle.
- ST_HOLD -> ST_COUNT on any counter write.
- Any state -> ST_IDLE when the enable bit is clear.

Top module: `presc_watchdog`

## Requirements
- R1: After reset every register reads zero, the watchdog is disabled and `sys_rst_req` is low.
- R2: Registers sit at byte offsets 0x0 (compare, 16 bits), 0x4 (enable, bit 0), 0x8 (counter, 16 bits) and 0xC (control, bits [5:0]). Unused bits read zero. A byte write (`bus_hw`=0) replaces only bits [7:0], and a halfword write replaces all 16 bits.
- R3: Control bits 0, 1 and 2 select `tick_per`, `tick_rtc` and `tick_ext`. When several are set, the lowest set bit wins. With none set, the counter never advances.
- R4: Control bits [5:3] hold a prescaler code. Codes 0..5 divide by 4^code, and codes 6 and 7 divide by 1024. With a tick every cycle, `sys_rst_req` first reads high 2 + compare*divisor clocks after the clock edge that accepts the enable write.
- R5: A write to the counter sets it to the written value. A write in the same cycle as a compare match takes priority and cancels that expiry.
- R6: While the enable bit is 0, the counter holds and no reset request is raised. Clearing the enable bit during a request drops the request one clock later.
- R7: On expiry, `sys_rst_req` stays high for exactly 16 clocks. The counter then stays at the compare value until software writes it.
- R8: Any write to the control register restarts the prescaler, so the next counter step comes a full prescale period later.
- R9: The block accepts this programming order: disable, control with the prescaler code only, compare value, counter clear, control with the source bit, enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous-release reset |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_hw | input | 1 | 1 = halfword write, 0 = byte write |
| bus_rdata | output | 16 | Read data of the addressed register |
| tick_per | input | 1 | Peripheral-clock tick strobe |
| tick_rtc | input | 1 | Real-time-clock tick strobe |
| tick_ext | input | 1 | External-clock tick strobe |
| sys_rst_req | output | 1 | Chip reset request |

## Verification
A kick and an expiry can land on the same clock edge: the counter equals the compare value, and software writes the counter in that very cycle. The bench provokes this by polling the counter until it reads the compare value and issuing the write on that same cycle. It then judges that no request appears and that counting restarts from the written value. A second collision, a control write landing mid-prescale, is judged by the exact delay to the next expiry.

// File: rtl/pwd_pkg.sv
package pwd_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_COUNT, ST_FIRE, ST_HOLD} wd_state_t;

    localparam int ADDR_W   = 4;
    localparam int BYTE_W   = 8;
    localparam int N_SRC    = 3;
    localparam int CODE_W   = 3;
    localparam int CTL_W    = N_SRC + CODE_W;
    localparam int MAX_CODE = 5;
    localparam int PS_W     = 2 * MAX_CODE;

    localparam logic [ADDR_W-1:0] OFS_CMP = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_EN  = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_CNT = 4'h8;
    localparam logic [ADDR_W-1:0] OFS_CTL = 4'hC;

    // terminal prescale count for a code; codes above MAX_CODE saturate
    function automatic logic [PS_W-1:0] ps_limit(input logic [CODE_W-1:0] code);
        logic [CODE_W-1:0] c;
        c = (code > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : code;
        return PS_W'((1 << (2 * c)) - 1);
    endfunction
endpackage

// File: rtl/pwd_regs.sv
module pwd_regs
    import pwd_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    input  logic              we,
    input  logic              size_hw,
    input  logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  cmp_q,
    output logic              en_q,
    output logic [CTL_W-1:0]  ctl_q,
    output logic              ctl_wr,
    output logic              cnt_wr,
    output logic [CNT_W-1:0]  cnt_wval,
    output logic [CNT_W-1:0]  rdata
);
    logic cmp_wr, en_wr;

    function automatic logic [CNT_W-1:0] merge(input logic [CNT_W-1:0] old,
                                               input logic [CNT_W-1:0] nw,
                                               input logic             hw);
        return hw ? nw : {old[CNT_W-1:BYTE_W], nw[BYTE_W-1:0]};
    endfunction

    always_comb begin
        cmp_wr   = we && (addr == OFS_CMP);
        en_wr    = we && (addr == OFS_EN);
        cnt_wr   = we && (addr == OFS_CNT);
        ctl_wr   = we && (addr == OFS_CTL);
        cnt_wval = merge(cnt, wdata, size_hw);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q <= '0;
            en_q  <= 1'b0;
            ctl_q <= '0;
        end else begin
            if (cmp_wr) cmp_q <= merge(cmp_q, wdata, size_hw);
            if (en_wr)  en_q  <= wdata[0];
            if (ctl_wr) ctl_q <= wdata[CTL_W-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_CMP: rdata = cmp_q;
            OFS_EN:  rdata = {{(CNT_W-1){1'b0}}, en_q};
            OFS_CNT: rdata = cnt;
            OFS_CTL: rdata = {{(CNT_W-CTL_W){1'b0}}, ctl_q};
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/pwd_prescale.sv
module pwd_prescale
    import pwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              clr,
    input  logic [N_SRC-1:0]  src_ticks,
    input  logic [N_SRC-1:0]  sel,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    logic [PS_W-1:0] pc_q;
    logic [PS_W-1:0] limit;
    logic            src;

    // lowest-numbered selected source wins: it is assigned last
    always_comb begin
        src = 1'b0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (sel[i]) src = src_ticks[i];
        end
        limit = ps_limit(code);
        tick  = run && src && (pc_q == limit) && !clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              pc_q <= '0;
        else if (clr || !run)    pc_q <= '0;
        else if (src)            pc_q <= (pc_q == limit) ? '0 : pc_q + 1'b1;
    end
endmodule

// File: rtl/pwd_ctrl.sv
module pwd_ctrl
    import pwd_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int PULSE_CLKS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic [CNT_W-1:0] cmp,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wval,
    output logic [CNT_W-1:0] cnt_q,
    output logic             run,
    output logic             rst_req
);
    localparam int PL_W = $clog2(PULSE_CLKS + 1);

    wd_state_t       st_q, st_d;
    logic [PL_W-1:0] pl_q;
    logic            match, last_pulse;

    assign match      = (cnt_q == cmp) && !cnt_wr;
    assign last_pulse = (pl_q == PL_W'(PULSE_CLKS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE:  st_d = ST_COUNT;
                ST_COUNT: if (match)      st_d = ST_FIRE;
                ST_FIRE:  if (last_pulse) st_d = ST_HOLD;
                ST_HOLD:  if (cnt_wr)     st_d = ST_COUNT;
            endcase
        end
    end

    always_comb begin
        run     = en && (st_q == ST_COUNT);
        rst_req = (st_q == ST_FIRE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                pl_q <= '0;
        else if (st_q == ST_FIRE)  pl_q <= pl_q + 1'b1;
        else                       pl_q <= '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             cnt_q <= '0;
        else if (cnt_wr)                        cnt_q <= cnt_wval;
        else if (run && tick && cnt_q != cmp)   cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/presc_watchdog.sv
module presc_watchdog
    import pwd_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int PULSE_CLKS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    input  logic              bus_we,
    input  logic              bus_hw,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              tick_per,
    input  logic              tick_rtc,
    input  logic              tick_ext,
    output logic              sys_rst_req
);
    logic [CNT_W-1:0] cmp_q, cnt_q, cnt_wval;
    logic [CTL_W-1:0] ctl_q;
    logic             en_q, ctl_wr, cnt_wr, run, tick;

    pwd_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata),
        .we(bus_we), .size_hw(bus_hw), .cnt(cnt_q), .cmp_q(cmp_q),
        .en_q(en_q), .ctl_q(ctl_q), .ctl_wr(ctl_wr), .cnt_wr(cnt_wr),
        .cnt_wval(cnt_wval), .rdata(bus_rdata)
    );

    pwd_prescale u_ps (
        .clk(clk), .rst_n(rst_n), .run(run), .clr(ctl_wr),
        .src_ticks({tick_ext, tick_rtc, tick_per}),
        .sel(ctl_q[N_SRC-1:0]), .code(ctl_q[CTL_W-1:N_SRC]), .tick(tick)
    );

    pwd_ctrl #(.CNT_W(CNT_W), .PULSE_CLKS(PULSE_CLKS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .en(en_q), .tick(tick), .cmp(cmp_q),
        .cnt_wr(cnt_wr), .cnt_wval(cnt_wval), .cnt_q(cnt_q), .run(run),
        .rst_req(sys_rst_req)
    );
endmodule

// File: rtl/pwd_checker.sv
module pwd_checker #(
    parameter int CNT_W      = 16,
    parameter int PULSE_CLKS = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rst_req,
    input logic             en,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cmp,
    input logic             cnt_wr
);
    localparam int RL_W = $clog2(PULSE_CLKS + 2) + 1;
    logic [RL_W-1:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       run_len <= '0;
        else if (rst_req) run_len <= run_len + 1'b1;
        else              run_len <= '0;
    end

    assert_pulse_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (run_len < RL_W'(PULSE_CLKS)));

    assert_frozen_fire_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req && !cnt_wr) |=> $stable(cnt));

    assert_no_req_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> !rst_req);

    assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

    assert_rise_on_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> $past(cnt == cmp && !cnt_wr));
endmodule

bind presc_watchdog pwd_checker #(.CNT_W(CNT_W), .PULSE_CLKS(PULSE_CLKS)) u_chk (
    .clk(clk), .rst_n(rst_n), .rst_req(sys_rst_req), .en(en_q),
    .cnt(cnt_q), .cmp(cmp_q), .cnt_wr(cnt_wr)
);

// File: tb/sim_presc_watchdog.sv
module sim_presc_watchdog;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = 4'h8;
    logic [15:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_hw = 1'b1;
    logic [15:0] bus_rdata;
    logic        tick_per = 1'b1;
    logic        tick_rtc = 1'b0;
    logic        tick_ext = 1'b0;
    logic        sys_rst_req;

    int n_cmp = 0, n_bad = 0, cyc = 0, tcyc = 0;
    bit done = 0;

    // reference model state
    int m_cmp, m_en, m_ctl, m_cnt, m_pc, m_st, m_fire;

    always #10 clk = ~clk;

    presc_watchdog u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_hw(bus_hw), .bus_rdata(bus_rdata),
        .tick_per(tick_per), .tick_rtc(tick_rtc), .tick_ext(tick_ext),
        .sys_rst_req(sys_rst_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // tick strobes: rtc every 3rd cycle, ext every 5th
    always @(negedge clk) begin
        cyc++;
        tick_rtc = (cyc % 3 == 0);
        tick_ext = (cyc % 5 == 0);
    end

    always @(posedge clk) begin
        tcyc++;
        if (tcyc > 150000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d expected 0", tcyc);
            finish_run();
        end
    end

    function automatic int mrg(int old, int nw, bit hw);
        return hw ? (nw & 'hFFFF) : ((old & 'hFF00) | (nw & 'hFF));
    endfunction

    // behavioural reference
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cmp = 0; m_en = 0; m_ctl = 0; m_cnt = 0; m_pc = 0; m_st = 0; m_fire = 0;
        end else begin
            bit w_cmp, w_en, w_cnt, w_ctl, src, run, tk;
            int code, lim, n_st, n_cnt, n_pc;
            w_cmp = bus_we && bus_addr == 4'h0;
            w_en  = bus_we && bus_addr == 4'h4;
            w_cnt = bus_we && bus_addr == 4'h8;
            w_ctl = bus_we && bus_addr == 4'hC;
            if (m_ctl & 1)      src = tick_per;
            else if (m_ctl & 2) src = tick_rtc;
            else if (m_ctl & 4) src = tick_ext;
            else                src = 0;
            code = (m_ctl >> 3) & 7;
            if (code > 5) code = 5;
            lim = (4 ** code) - 1;
            run = (m_en != 0) && m_st == 1;
            tk  = run && src && m_pc == lim && !w_ctl;
            n_pc = (w_ctl || !run) ? 0 : (src ? (m_pc == lim ? 0 : m_pc + 1) : m_pc);
            n_st = m_st;
            if (m_en == 0) n_st = 0;
            else if (m_st == 0) n_st = 1;
            else if (m_st == 1 && m_cnt == m_cmp && !w_cnt) n_st = 2;
            else if (m_st == 2 && m_fire == 15) n_st = 3;
            else if (m_st == 3 && w_cnt) n_st = 1;
            if (w_cnt) n_cnt = mrg(m_cnt, bus_wdata, bus_hw);
            else if (tk && m_cnt != m_cmp) n_cnt = (m_cnt + 1) & 'hFFFF;
            else n_cnt = m_cnt;
            m_fire = (m_st == 2) ? m_fire + 1 : 0;
            if (w_cmp) m_cmp = mrg(m_cmp, bus_wdata, bus_hw);
            if (w_en)  m_en  = bus_wdata[0];
            if (w_ctl) m_ctl = bus_wdata[5:0];
            m_st = n_st; m_cnt = n_cnt; m_pc = n_pc;
        end
    end

    function automatic int m_read(logic [3:0] a);
        case (a)
            4'h0: return m_cmp;
            4'h4: return m_en;
            4'h8: return m_cnt;
            4'hC: return m_ctl;
            default: return 0;
        endcase
    endfunction

    // per-clock comparison, away from both edges
    always @(negedge clk) begin
        #5;
        if (rst_n && !done) begin
            chk("R7 model sys_rst_req", 32'(sys_rst_req), 32'(m_st == 2));
            chk("R2 model bus_rdata", 32'(bus_rdata), 32'(m_read(bus_addr)));
        end
    end

    task automatic wr_now(input logic [3:0] a, input logic [15:0] d, input bit hw);
        bus_we = 1; bus_addr = a; bus_wdata = d; bus_hw = hw;
        @(negedge clk);
        bus_we = 0; bus_addr = 4'h8; bus_hw = 1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d, input bit hw);
        @(negedge clk);
        wr_now(a, d, hw);
    endtask

    task automatic rd(input logic [3:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #2;
        chk(tag, 32'(bus_rdata), 32'(exp));
        bus_addr = 4'h8;
    endtask

    task automatic program_wd(input int code, input int cmpv, input int srcb);
        wr(4'h4, 0, 1);
        wr(4'hC, 16'(code << 3), 1);
        wr(4'h0, 16'(cmpv), 1);
        wr(4'h8, 0, 1);
        wr(4'hC, 16'((code << 3) | srcb), 1);
        wr(4'h4, 1, 1);
    endtask

    task automatic wait_fire(output int n);
        n = 0;
        do begin
            @(posedge clk); n++;
            @(negedge clk);
        end while (!sys_rst_req && n < 8000);
    endtask

    initial begin
        int n, len;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(4'h0, 0, "R1 compare after reset");
        rd(4'h4, 0, "R1 enable after reset");
        rd(4'h8, 0, "R1 counter after reset");
        rd(4'hC, 0, "R1 control after reset");
        chk("R1 request after reset", 32'(sys_rst_req), 0);

        // R2 readback and byte writes
        wr(4'h0, 16'hABCD, 1); rd(4'h0, 16'hABCD, "R2 compare halfword");
        wr(4'h0, 16'h5512, 0); rd(4'h0, 16'hAB12, "R2 compare byte");
        wr(4'hC, 16'hFFC0, 1); rd(4'hC, 16'h0000, "R2 control unused bits");
        wr(4'h8, 16'h1234, 1); rd(4'h8, 16'h1234, "R2 counter write");
        wr(4'h4, 16'hFFFE, 1); rd(4'h4, 16'h0000, "R2 enable bit0 only");

        // R4 timeout per prescaler code, R9 programming order, R7 pulse and hold
        for (int code = 0; code < 8; code++) begin
            int dv;
            dv = (code > 5) ? 1024 : (4 ** code);
            program_wd(code, 3, 1);
            wait_fire(n);
            chk($sformatf("R4 R9 timeout code %0d", code), 32'(n), 32'(2 + 3 * dv));
            len = 1;
            while (sys_rst_req && len < 100) begin @(negedge clk); if (sys_rst_req) len++; end
            chk("R7 pulse length", 32'(len), 16);
            repeat (30) @(negedge clk);
            chk("R7 held low after pulse", 32'(sys_rst_req), 0);
            chk("R7 counter held", 32'(bus_rdata), 3);
        end

        // R5 kick in the match cycle cancels expiry
        program_wd(0, 30, 1);
        n = 0;
        do begin @(negedge clk); n++; end while (bus_rdata != 30 && n < 200);
        wr_now(4'h8, 16'd5, 1);
        chk("R5 kick value", 32'(bus_rdata), 5);
        len = 0;
        repeat (20) begin @(negedge clk); if (sys_rst_req) len++; end
        chk("R5 no request after same-cycle kick", 32'(len), 0);
        // periodic kicks before expiry
        repeat (5) begin
            do @(negedge clk); while (bus_rdata != 28);
            wr_now(4'h8, 0, 1);
        end
        chk("R5 periodic kicks keep request low", 32'(sys_rst_req), 0);

        // R3 no source selected
        program_wd(0, 4, 0);
        repeat (200) @(negedge clk);
        chk("R3 no source counter", 32'(bus_rdata), 0);
        chk("R3 no source request", 32'(sys_rst_req), 0);
        // R3 priority: rtc and ext selected, rtc (bit 1) wins
        program_wd(0, 4, 6);
        wait_fire(n);
        chk("R3 rtc wins lower bound", 32'(n >= 12), 1);
        chk("R3 rtc wins upper bound", 32'(n <= 14), 1);

        // R8 control write restarts prescaler
        program_wd(2, 1, 1);
        repeat (10) @(negedge clk);
        wr(4'hC, 16'((2 << 3) | 1), 1);
        wait_fire(n);
        chk("R8 delay after control rewrite", 32'(n), 17);

        // R6 disable during request drops it one clock later
        wr_now(4'h4, 0, 1);
        chk("R6 request still high", 32'(sys_rst_req), 1);
        @(negedge clk);
        chk("R6 request dropped", 32'(sys_rst_req), 0);
        // R6 disabled: no counting, no request
        wr(4'h8, 0, 1);
        wr(4'h0, 2, 1);
        len = 0;
        repeat (300) begin @(negedge clk); if (sys_rst_req) len++; end
        chk("R6 disabled no request", 32'(len), 0);
        chk("R6 disabled counter held", 32'(bus_rdata), 0);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule